// File: doc/BRIEF.md
# Multi-DAC Frame Output Sequencer

This block paces conversion strobes for a bank of DACs that are loaded over serial links. The strobes come at a programmable rate and are grouped into frames. A frame starts on a trigger and holds a fixed number of conversions. After the last conversion of a frame the sequencer waits for the next trigger.

The DACs are selected by a participation mask. Each rate tick is turned into a conversion strobe only when two things hold for every selected DAC:

- the DAC reports that its next sample is loaded;
- the DAC is outside its serial-transfer guard window.

Three faults are watched:

- a trigger that arrives while a frame is still running;
- a rate tick that lands in a guard window;
- a rate tick that finds a DAC without data.

Any fault sets a sticky flag, stops all strobes and halts the unit. The flags clear only when the unit enable is dropped. The serial shifting itself is outside this block. Each DAC is represented here by its `loaded` and `guard` status bits.

Top module: `dac_frame_seq`

## Requirements
- R1: While reset is asserted, or while `enable` is low, `conv_pulse`, `frame_active`, `halted` and all three error flags are 0.
- R2: With rate setting D, the first `conv_pulse` rises D+1 clocks after the clock edge that accepted the trigger. Later strobes follow every D+1 clocks, and each strobe is exactly one clock wide.
- R3: A frame emits exactly `frame_len` strobes. `frame_active` then falls and no strobe is emitted until the next trigger. A trigger with `frame_len` = 0 starts nothing.
- R4: A trigger is taken on the rising edge of `frame_trig`. Holding it high for many clocks starts only one frame and raises no frame error.
- R5: A trigger rising edge while `frame_active` is 1 sets `err_frame` and `halted`, and clears `frame_active`.
- R6: A rate tick while any DAC with its bit set in `dac_mask` has its bit set in `dac_guard` sets `err_timing`, and no strobe is emitted for that tick.
- R7: A rate tick while any masked DAC has its bit clear in `dac_loaded` sets `err_underrun`, and no strobe is emitted for that tick. This holds mid-frame too; strobes already emitted are kept.
- R8: DACs whose `dac_mask` bit is 0 are ignored by both checks.
- R9: While `halted` is 1, no strobe is emitted, triggers start no frame, and no new error flag is set.
- R10: The error flags and `halted` stay set while `enable` remains high. One clock with `enable` low clears them all, and the unit then runs normal frames again.
- R11: When several faults are detected on the same clock, every matching flag is set together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Unit enable; low clears errors and stops the unit |
| rate_div | input | DIV_W | Rate setting D; one tick every D+1 clocks |
| frame_len | input | CNT_W | Conversions per frame |
| frame_trig | input | 1 | Frame trigger (rising edge with TRIG_EDGE=1) |
| dac_mask | input | NUM_DAC | DACs that take part in the checks |
| dac_loaded | input | NUM_DAC | Per-DAC next sample preloaded |
| dac_guard | input | NUM_DAC | Per-DAC inside serial-transfer guard window |
| conv_pulse | output | 1 | One-clock conversion strobe |
| frame_active | output | 1 | A frame is in progress |
| halted | output | 1 | Unit stopped by a fault |
| err_frame | output | 1 | Sticky frame overrun flag |
| err_timing | output | 1 | Sticky guard-window timing flag |
| err_underrun | output | 1 | Sticky data underrun flag |

## Verification
The bench measures the exact latency from trigger to first strobe and the strobe spacing. A design with an off-by-one in the divider would shift the first strobe or stretch the period. It also checks that a held trigger starts one frame only; a level-sensitive start would flag a false overrun. Masked-out DACs that are busy or empty must not stop a frame. A fault that appears mid-frame must keep the strobes already emitted and block the one at fault; a design that checks late would leak one extra strobe. After a halt, further triggers and guard hits must leave the flags unchanged and produce no strobe. A single clock of disable must clear everything and allow a clean frame afterwards.

// File: rtl/dfs_pkg.sv
package dfs_pkg;
   typedef struct packed {
      logic frame;
      logic timing;
      logic underrun;
   } dfs_err_t;

   localparam dfs_err_t DFS_NO_ERR = '{frame: 1'b0, timing: 1'b0, underrun: 1'b0};
endpackage

// File: rtl/dfs_rate_div.sv
module dfs_rate_div #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] limit,
   output logic             tick
);
   logic [DIV_W-1:0] cnt_q;
   logic             at_end;

   assign at_end = (cnt_q >= limit);
   assign tick   = run & at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!run || at_end)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/dfs_trig_det.sv
module dfs_trig_det #(
   parameter bit TRIG_EDGE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig_in,
   output logic trig_evt
);
   generate
      if (TRIG_EDGE) begin : g_edge
         logic trig_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) trig_q <= 1'b0;
            else        trig_q <= trig_in;
         end
         assign trig_evt = trig_in & ~trig_q;
      end else begin : g_level
         assign trig_evt = trig_in;
      end
   endgenerate
endmodule

// File: rtl/dfs_qualify.sv
module dfs_qualify #(
   parameter int NUM_DAC = 4
) (
   input  logic [NUM_DAC-1:0] mask,
   input  logic [NUM_DAC-1:0] loaded,
   input  logic [NUM_DAC-1:0] guard,
   output logic               timing_bad,
   output logic               underrun_bad
);
   logic [NUM_DAC-1:0] in_window;
   logic [NUM_DAC-1:0] empty;

   genvar i;
   generate
      for (i = 0; i < NUM_DAC; i++) begin : g_dac
         assign in_window[i] = mask[i] & guard[i];
         assign empty[i]     = mask[i] & ~loaded[i];
      end
   endgenerate

   assign timing_bad   = |in_window;
   assign underrun_bad = |empty;
endmodule

// File: rtl/dfs_frame_ctl.sv
module dfs_frame_ctl
   import dfs_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             trig_evt,
   input  logic             req,
   input  logic             timing_bad,
   input  logic             underrun_bad,
   input  logic [CNT_W-1:0] frame_len,
   output logic             active,
   output logic             pulse,
   output dfs_err_t         errs,
   output logic             halted
);
   logic [CNT_W-1:0] remain_q;
   dfs_err_t         new_err;
   logic             start;

   assign halted = |errs;

   always_comb begin
      new_err.frame    = trig_evt & active;
      new_err.timing   = req & timing_bad;
      new_err.underrun = req & underrun_bad;
   end

   assign start = trig_evt & ~active & (frame_len != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remain_q <= '0;
         active   <= 1'b0;
         pulse    <= 1'b0;
         errs     <= DFS_NO_ERR;
      end else if (!enable) begin
         remain_q <= '0;
         active   <= 1'b0;
         pulse    <= 1'b0;
         errs     <= DFS_NO_ERR;
      end else begin
         pulse <= 1'b0;
         if (!halted) begin
            if (|new_err) begin
               errs   <= new_err;
               active <= 1'b0;
            end else if (req) begin
               pulse    <= 1'b1;
               remain_q <= remain_q - 1'b1;
               if (remain_q <= 1) active <= 1'b0;
            end else if (start) begin
               active   <= 1'b1;
               remain_q <= frame_len;
            end
         end
      end
   end
endmodule

// File: rtl/dac_frame_seq.sv
module dac_frame_seq
   import dfs_pkg::*;
#(
   parameter int NUM_DAC   = 4,
   parameter int DIV_W     = 8,
   parameter int CNT_W     = 8,
   parameter bit TRIG_EDGE = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               enable,
   input  logic [DIV_W-1:0]   rate_div,
   input  logic [CNT_W-1:0]   frame_len,
   input  logic               frame_trig,
   input  logic [NUM_DAC-1:0] dac_mask,
   input  logic [NUM_DAC-1:0] dac_loaded,
   input  logic [NUM_DAC-1:0] dac_guard,
   output logic               conv_pulse,
   output logic               frame_active,
   output logic               halted,
   output logic               err_frame,
   output logic               err_timing,
   output logic               err_underrun
);
   generate
      if (NUM_DAC < 1 || NUM_DAC > 64) begin : g_bad_dac
         $error("dac_frame_seq: NUM_DAC out of range");
      end
      if (DIV_W < 1 || DIV_W > 32) begin : g_bad_div
         $error("dac_frame_seq: DIV_W out of range");
      end
      if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt
         $error("dac_frame_seq: CNT_W out of range");
      end
   endgenerate

   logic     trig_evt;
   logic     rate_tick;
   logic     timing_bad;
   logic     underrun_bad;
   logic     run_div;
   dfs_err_t errs;

   assign run_div = enable & frame_active & ~halted;

   dfs_trig_det #(.TRIG_EDGE(TRIG_EDGE)) u_trig (
      .clk      (clk),
      .rst_n    (rst_n),
      .trig_in  (frame_trig),
      .trig_evt (trig_evt)
   );

   dfs_rate_div #(.DIV_W(DIV_W)) u_rate (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run_div),
      .limit (rate_div),
      .tick  (rate_tick)
   );

   dfs_qualify #(.NUM_DAC(NUM_DAC)) u_qual (
      .mask         (dac_mask),
      .loaded       (dac_loaded),
      .guard        (dac_guard),
      .timing_bad   (timing_bad),
      .underrun_bad (underrun_bad)
   );

   dfs_frame_ctl #(.CNT_W(CNT_W)) u_ctl (
      .clk          (clk),
      .rst_n        (rst_n),
      .enable       (enable),
      .trig_evt     (trig_evt),
      .req          (rate_tick),
      .timing_bad   (timing_bad),
      .underrun_bad (underrun_bad),
      .frame_len    (frame_len),
      .active       (frame_active),
      .pulse        (conv_pulse),
      .errs         (errs),
      .halted       (halted)
   );

   assign err_frame    = errs.frame;
   assign err_timing   = errs.timing;
   assign err_underrun = errs.underrun;
endmodule

// File: rtl/dfs_checker.sv
module dfs_checker #(
   parameter int NUM_DAC = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               enable,
   input logic [NUM_DAC-1:0] dac_mask,
   input logic [NUM_DAC-1:0] dac_loaded,
   input logic [NUM_DAC-1:0] dac_guard,
   input logic               conv_pulse,
   input logic               frame_active,
   input logic               halted,
   input logic               err_frame,
   input logic               err_timing,
   input logic               err_underrun
);
   AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (!err_frame && !err_timing && !err_underrun && !conv_pulse && !frame_active)); // R1

   AST_PULSE_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      conv_pulse |-> $past(frame_active)); // R3

   AST_PULSE_NO_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
      conv_pulse |-> $past((dac_mask & dac_guard) == '0)); // R6

   AST_PULSE_ALL_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
      conv_pulse |-> $past((dac_mask & ~dac_loaded) == '0)); // R7

   AST_HALT_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> (!conv_pulse && !frame_active)); // R9

   AST_STICKY_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      (err_frame && enable) |=> err_frame); // R10

   AST_STICKY_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
      (err_timing && enable) |=> err_timing); // R10

   AST_STICKY_UNDERRUN: assert property (@(posedge clk) disable iff (!rst_n)
      (err_underrun && enable) |=> err_underrun); // R10
endmodule

bind dac_frame_seq dfs_checker #(.NUM_DAC(NUM_DAC)) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .enable       (enable),
   .dac_mask     (dac_mask),
   .dac_loaded   (dac_loaded),
   .dac_guard    (dac_guard),
   .conv_pulse   (conv_pulse),
   .frame_active (frame_active),
   .halted       (halted),
   .err_frame    (err_frame),
   .err_timing   (err_timing),
   .err_underrun (err_underrun)
);

// File: tb/dac_frame_seq_tb.sv
module dac_frame_seq_tb_top;
   localparam int N  = 4;
   localparam int DW = 8;
   localparam int CW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          enable = 1'b0;
   logic [DW-1:0] rate_div = '0;
   logic [CW-1:0] frame_len = '0;
   logic          frame_trig = 1'b0;
   logic [N-1:0]  dac_mask = '0;
   logic [N-1:0]  dac_loaded = '0;
   logic [N-1:0]  dac_guard = '0;
   logic          conv_pulse, frame_active, halted;
   logic          err_frame, err_timing, err_underrun;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   dac_frame_seq #(.NUM_DAC(N), .DIV_W(DW), .CNT_W(CW), .TRIG_EDGE(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .enable(enable), .rate_div(rate_div),
      .frame_len(frame_len), .frame_trig(frame_trig), .dac_mask(dac_mask),
      .dac_loaded(dac_loaded), .dac_guard(dac_guard), .conv_pulse(conv_pulse),
      .frame_active(frame_active), .halted(halted), .err_frame(err_frame),
      .err_timing(err_timing), .err_underrun(err_underrun)
   );

   typedef struct packed {
      logic [DW-1:0] dv;
      logic [CW-1:0] len;
      logic [N-1:0]  msk;
      logic [N-1:0]  ld;
      logic [N-1:0]  gd;
      logic [7:0]    npulse;
      logic [2:0]    err;
   } vec_t;

   // err field: {frame, timing, underrun}
   localparam vec_t VECS [8] = '{
      '{dv: 8'd0, len: 8'd3, msk: 4'hF, ld: 4'hF, gd: 4'h0, npulse: 8'd3, err: 3'b000}, // R2 R3
      '{dv: 8'd2, len: 8'd5, msk: 4'hF, ld: 4'hF, gd: 4'h0, npulse: 8'd5, err: 3'b000}, // R2 R3
      '{dv: 8'd1, len: 8'd4, msk: 4'h3, ld: 4'h3, gd: 4'hC, npulse: 8'd4, err: 3'b000}, // R8
      '{dv: 8'd1, len: 8'd4, msk: 4'hF, ld: 4'hE, gd: 4'h0, npulse: 8'd0, err: 3'b001}, // R7
      '{dv: 8'd3, len: 8'd2, msk: 4'h5, ld: 4'hF, gd: 4'h4, npulse: 8'd0, err: 3'b010}, // R6
      '{dv: 8'd0, len: 8'd2, msk: 4'hF, ld: 4'h7, gd: 4'h1, npulse: 8'd0, err: 3'b011}, // R11
      '{dv: 8'd2, len: 8'd0, msk: 4'hF, ld: 4'hF, gd: 4'h0, npulse: 8'd0, err: 3'b000}, // R3
      '{dv: 8'd4, len: 8'd1, msk: 4'h1, ld: 4'h1, gd: 4'h0, npulse: 8'd1, err: 3'b000}  // R3
   };

   task automatic check(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int err_bits();
      return {29'd0, err_frame, err_timing, err_underrun};
   endfunction

   task automatic count_pulses(int cycles, output int n);
      n = 0;
      repeat (cycles) begin
         @(negedge clk);
         if (conv_pulse) n++;
      end
   endtask

   task automatic fire_trig();
      frame_trig = 1'b1;
      @(negedge clk);
      frame_trig = 1'b0;
   endtask

   task automatic cycle_enable();
      enable = 1'b0;
      @(negedge clk);
      enable = 1'b1;
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int n;
      int first_k;
      int second_k;
      int wide;
      int act_seen;

      // Reset state, enable already high
      enable = 1'b1;
      repeat (3) @(negedge clk);
      check("R1", "pulse in reset", conv_pulse, 0);
      check("R1", "errors/halt in reset", {frame_active, halted, err_bits() != 0}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // Vector table
      foreach (VECS[v]) begin
         enable = 1'b0;
         @(negedge clk);
         check("R1", "disabled outputs", {conv_pulse, frame_active, halted, err_bits() != 0}, 0);
         rate_div   = VECS[v].dv;
         frame_len  = VECS[v].len;
         dac_mask   = VECS[v].msk;
         dac_loaded = VECS[v].ld;
         dac_guard  = VECS[v].gd;
         enable     = 1'b1;
         @(negedge clk);
         fire_trig();
         count_pulses((int'(VECS[v].len) + 1) * (int'(VECS[v].dv) + 1) + 6, n);
         check("R3", $sformatf("vec %0d pulse count", v), n, int'(VECS[v].npulse));
         check("R11", $sformatf("vec %0d error flags", v), err_bits(), int'(VECS[v].err));
         check("R9", $sformatf("vec %0d halted", v), halted, int'(VECS[v].err != 0));
      end

      // Latency, spacing, width (R2) and idle after frame (R3)
      cycle_enable();
      rate_div = 8'd3; frame_len = 8'd2;
      dac_mask = 4'hF; dac_loaded = 4'hF; dac_guard = 4'h0;
      @(negedge clk);
      first_k = 0; second_k = 0; wide = 0;
      frame_trig = 1'b1;
      for (int k = 1; k <= 12; k++) begin
         @(negedge clk);
         frame_trig = 1'b0;
         if (conv_pulse) begin
            if (first_k == 0) first_k = k;
            else if (second_k == 0) second_k = k;
            if (k == first_k + 1) wide = 1;
         end
         if (k == 10) check("R3", "frame_active after last strobe", frame_active, 0);
      end
      check("R2", "first strobe latency", first_k, 5);
      check("R2", "strobe spacing", second_k - first_k, 4);
      check("R2", "strobe width", wide, 0);
      count_pulses(12, n);
      check("R3", "no strobe while idle", n, 0);

      // Held trigger (R4)
      cycle_enable();
      rate_div = 8'd0; frame_len = 8'd2;
      @(negedge clk);
      frame_trig = 1'b1;
      count_pulses(12, n);
      frame_trig = 1'b0;
      check("R4", "held trigger strobes", n, 2);
      check("R4", "held trigger no frame error", err_frame, 0);

      // Mid-frame underrun keeps earlier strobes (R7)
      cycle_enable();
      rate_div = 8'd1; frame_len = 8'd6;
      @(negedge clk);
      frame_trig = 1'b1;
      count_pulses(6, n);
      frame_trig = 1'b0;
      dac_loaded = 4'hE;
      count_pulses(1, wide);
      n = n + wide;
      count_pulses(10, wide);
      n = n + wide;
      check("R7", "strobes before underrun", n, 2);
      check("R7", "mid-frame underrun flag", err_underrun, 1);
      dac_loaded = 4'hF;

      // Frame overrun (R5), halted behaviour (R9), sticky and clear (R10)
      cycle_enable();
      rate_div = 8'd5; frame_len = 8'd4;
      @(negedge clk);
      fire_trig();
      repeat (2) @(negedge clk);
      fire_trig();
      check("R5", "frame error flag", err_frame, 1);
      check("R5", "halted on frame error", halted, 1);
      check("R5", "frame_active cleared", frame_active, 0);
      count_pulses(30, n);
      check("R9", "no strobe while halted", n, 0);
      dac_guard = 4'hF;
      fire_trig();
      act_seen = 0;
      repeat (10) begin
         @(negedge clk);
         if (frame_active || conv_pulse) act_seen = 1;
      end
      check("R9", "trigger ignored while halted", act_seen, 0);
      check("R9", "no new flag while halted", err_bits(), 3'b100);
      check("R10", "flag sticky while enabled", err_frame, 1);
      dac_guard = 4'h0;
      enable = 1'b0;
      @(negedge clk);
      check("R10", "flags cleared by disable", {halted, err_bits() != 0}, 0);
      enable = 1'b1;
      @(negedge clk);
      fire_trig();
      count_pulses(40, n);
      check("R10", "frame after re-enable", n, 4);
      check("R10", "clean after re-enable", err_bits(), 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule